// File: doc/BRIEF.md
# Command Queue Status and Interrupt-Control Register Block

This block sits in the 2D register window of a graphics accelerator. It answers reads of two registers. The first is a status word, built on the fly from the command-queue occupancy and the number of buffer swaps still pending. The second is a stored interrupt-control word.

Every write into the window, except one, is forwarded to the command queue. Each forwarded write goes out on a valid/ready port as an address/data pair. The exception is a write to the interrupt-control offset: it updates the register directly, without passing through the queue and without waiting for it.

Status layout:

| Bits | Content |
|------|---------|
| 4:0 | Free-slot count |
| 5 | Busy flag |
| 30:28 | Pending swap count |
| All others | Zero |

Register offsets, as byte addresses within the window (bits 1:0 of the address are ignored):

| Offset | Register |
|--------|----------|
| 0x000 | Status |
| 0x004 | Interrupt control |

Top module: `fifoStatusRegs`

## Requirements
- R1: Status bits 4:0 read 31 minus the queue entry count while the count is below 32, and read 0 when the count is 32 or more.
- R2: Status bit 5 reads 1 whenever the entry count is non-zero, and 0 when the queue is empty.
- R3: Status bits 30:28 carry the pending swap count when it is below 7, and read 0 for a count of 7. Status bits 27:6 and bit 31 always read 0.
- R4: A write to offset 0x004 stores the write data masked with 0x0030003F on the next clock edge. A read of offset 0x004 returns the stored value, and all bits outside the mask read 0.
- R5: After reset, the interrupt-control register holds 0 and fwdValid is 0.
- R6: A write to offset 0x004 is always accepted (wrReady is 1), even while the queue is stalled. Such a write never produces a forwarded entry.
- R7: A write to any other offset appears on fwdValid/fwdAddr/fwdData one cycle later. The pair then stays unchanged until a cycle in which fwdReady is 1.
- R8: While a forwarded pair is held and fwdReady is 0, wrReady is 0 for non-direct writes. Such a write is dropped and leaves the held pair unchanged. When fwdReady is 1, a new write replaces the pair in the same cycle.
- R9: Reads are combinational in the cycle rdEn is high. Unmapped offsets read 0, and rdData is 0 while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoCount | input | 7 | Current command-queue entry count |
| swapCount | input | 3 | Pending buffer-swap count |
| regAddr | input | 9 | Byte address within the window |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| wrReady | output | 1 | Write accepted this cycle |
| rdData | output | 32 | Read data |
| fwdValid | output | 1 | Forwarded write pending |
| fwdAddr | output | 9 | Forwarded write address |
| fwdData | output | 32 | Forwarded write data |
| fwdReady | input | 1 | Command queue accepts the pending write |

## Verification
Read data and wrReady are due in the same cycle as the strobe. The bench therefore checks them a short delay after driving inputs at the falling edge, before the next rising edge.

Interrupt-control updates and forwarded pairs are due one rising edge after the write. These are checked at the following falling edge, against a bench model that is advanced only at that edge.

A seeded random phase mixes stalls, direct writes and reads. This phase follows directed cases for the saturation boundaries and the stall/replace ordering.

// File: rtl/fifo_status_pkg.sv
package fifo_status_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] INTR_MASK = 32'h0030_003F;
  localparam int FREE_W = 5;
  localparam int FREE_MAX = (1 << FREE_W) - 1;
  localparam int BUSY_BIT = FREE_W;
  localparam int SWAP_LSB = 28;

  typedef struct packed {
    logic selStatus;
    logic selIntr;
    logic loadIntr;
    logic loadFwd;
    logic popFwd;
  } ctlStrobes_t;
endpackage

// File: rtl/fifo_status_ctl.sv
module fifo_status_ctl
  import fifo_status_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-1:0] STATUS_OFS = '0,
  parameter logic [ADDR_W-1:0] INTR_OFS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              fwdValid,
  input  logic              fwdReady,
  output logic              wrReady,
  output ctlStrobes_t       strobes
);
  localparam int WORD_W = ADDR_W - 2;

  logic hitStatus;
  logic hitIntr;
  logic queueFree;

  assign hitStatus = regAddr[ADDR_W-1:2] == STATUS_OFS[ADDR_W-1:2];
  assign hitIntr   = regAddr[ADDR_W-1:2] == INTR_OFS[ADDR_W-1:2];
  assign queueFree = !fwdValid || fwdReady;

  always_comb begin
    wrReady           = hitIntr || queueFree;
    strobes.selStatus = rdEn && hitStatus;
    strobes.selIntr   = rdEn && hitIntr;
    strobes.loadIntr  = wrEn && hitIntr;
    strobes.loadFwd   = wrEn && !hitIntr && queueFree;
    strobes.popFwd    = fwdValid && fwdReady;
  end

  // R6: a direct write is never held back by a stalled queue
  a_r6_direct_accept: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hitIntr) |-> wrReady);

  // R8: nothing new is loaded while the held pair is refused
  a_r8_no_load_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdReady) |-> !strobes.loadFwd);

  logic [WORD_W-1:0] unusedWord;
  assign unusedWord = regAddr[ADDR_W-1:2];
endmodule

// File: rtl/fifo_status_dp.sv
module fifo_status_dp
  import fifo_status_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int COUNT_W = 7,
  parameter int SWAP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [COUNT_W-1:0] fifoCount,
  input  logic [SWAP_W-1:0] swapCount,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              fwdValid,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdData
);
  localparam int SWAP_LIMIT = (1 << SWAP_W) - 1;
  localparam int SAT_COUNT = FREE_MAX + 1;

  logic [DATA_W-1:0] intrReg;
  logic [DATA_W-1:0] statusWord;
  logic [FREE_W-1:0] freeSlots;
  logic              queueBusy;

  // status encoding
  always_comb begin
    if (32'(fifoCount) < SAT_COUNT)
      freeSlots = FREE_W'(FREE_MAX) - fifoCount[FREE_W-1:0];
    else
      freeSlots = '0;
    queueBusy = fifoCount != '0;
    statusWord = '0;
    statusWord[FREE_W-1:0] = freeSlots;
    statusWord[BUSY_BIT] = queueBusy;
    if (32'(swapCount) < SWAP_LIMIT)
      statusWord[SWAP_LSB +: SWAP_W] = swapCount;
  end

  // read mux
  always_comb begin
    rdData = '0;
    if (strobes.selStatus)
      rdData = statusWord;
    else if (strobes.selIntr)
      rdData = intrReg;
  end

  // direct-write register
  always_ff @(posedge clk) begin
    if (!rstN)
      intrReg <= '0;
    else if (strobes.loadIntr)
      intrReg <= wrData & INTR_MASK;
  end

  // forwarded write holding stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0;
      fwdAddr  <= '0;
      fwdData  <= '0;
    end else if (strobes.loadFwd) begin
      fwdValid <= 1'b1;
      fwdAddr  <= regAddr;
      fwdData  <= wrData;
    end else if (strobes.popFwd) begin
      fwdValid <= 1'b0;
    end
  end

  // R4: stored value is the masked write data of the previous cycle
  a_r4_masked_store: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadIntr |=> intrReg == ($past(wrData) & INTR_MASK));

  // R7: a refused pair stays in place
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !strobes.popFwd && !strobes.loadFwd) |=>
      (fwdValid && $stable(fwdAddr) && $stable(fwdData)));

  // R2, R1: an idle queue always shows the full free count
  always_comb begin
    if (rstN && !statusWord[BUSY_BIT])
      a_r1_idle_full: assert (statusWord[FREE_W-1:0] == FREE_W'(FREE_MAX));
  end

  // R3: no stray bits in the status word
  always_comb begin
    if (rstN)
      a_r3_reserved_zero: assert (statusWord[SWAP_LSB-1:BUSY_BIT+1] == '0 &&
        statusWord[DATA_W-1:SWAP_LSB+SWAP_W] == '0);
  end
endmodule

// File: rtl/fifoStatusRegs.sv
module fifoStatusRegs
  import fifo_status_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int COUNT_W = 7,
  parameter int SWAP_W = 3,
  parameter logic [ADDR_W-1:0] STATUS_OFS = '0,
  parameter logic [ADDR_W-1:0] INTR_OFS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COUNT_W-1:0] fifoCount,
  input  logic [SWAP_W-1:0]  swapCount,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic               wrReady,
  output logic [31:0]        rdData,
  output logic               fwdValid,
  output logic [ADDR_W-1:0]  fwdAddr,
  output logic [31:0]        fwdData,
  input  logic               fwdReady
);
  ctlStrobes_t strobes;

  fifo_status_ctl #(
    .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .INTR_OFS(INTR_OFS)
  ) ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .rdEn(rdEn), .wrEn(wrEn),
    .fwdValid(fwdValid), .fwdReady(fwdReady), .wrReady(wrReady),
    .strobes(strobes)
  );

  fifo_status_dp #(
    .ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .SWAP_W(SWAP_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .fifoCount(fifoCount),
    .swapCount(swapCount), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .fwdValid(fwdValid), .fwdAddr(fwdAddr),
    .fwdData(fwdData)
  );

  // R5: the forward port comes out of reset empty
  a_r5_reset_empty: assert property (@(posedge clk)
    !rstN |=> !fwdValid);
endmodule

// File: tb/fifoStatusRegs_test.sv
module fifoStatusRegs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [6:0]  fifoCount = 0;
  logic [2:0]  swapCount = 0;
  logic [8:0]  regAddr = 0;
  logic        rdEn = 0;
  logic        wrEn = 0;
  logic [31:0] wrData = 0;
  logic        wrReady;
  logic [31:0] rdData;
  logic        fwdValid;
  logic [8:0]  fwdAddr;
  logic [31:0] fwdData;
  logic        fwdReady = 0;

  int checks = 0;
  int errors = 0;
  logic        mValid = 0;
  logic [8:0]  mAddr = 0;
  logic [31:0] mData = 0;
  logic [31:0] mIntr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifoStatusRegs uut (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .swapCount(swapCount),
    .regAddr(regAddr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .wrReady(wrReady), .rdData(rdData), .fwdValid(fwdValid),
    .fwdAddr(fwdAddr), .fwdData(fwdData), .fwdReady(fwdReady)
  );

  function automatic logic [31:0] expStatus(int cnt, int sw);
    logic [31:0] s = 0;
    if (cnt < 32) s[4:0] = 5'(31 - cnt);
    if (cnt != 0) s[5] = 1'b1;
    if (sw < 7) s[30:28] = 3'(sw);
    return s;
  endfunction

  function automatic logic [31:0] expRead(logic en, logic [8:0] a, int cnt, int sw, logic [31:0] intr);
    if (!en) return 0;
    if (a[8:2] == 0) return expStatus(cnt, sw);
    if (a[8:2] == 1) return intr;
    return 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkFwd(string req);
    check(req, {31'd0, fwdValid}, {31'd0, mValid});
    if (mValid) begin
      check(req, {23'd0, fwdAddr}, {23'd0, mAddr});
      check(req, fwdData, mData);
    end
  endtask

  // drive at falling edge, check combinational results, model the rising edge
  task automatic cycle(logic r, logic w, logic [8:0] a, logic [31:0] d, logic rdy,
                       int cnt, int sw);
    logic isIntr;
    logic expRdy;
    rdEn = r; wrEn = w; regAddr = a; wrData = d; fwdReady = rdy;
    fifoCount = 7'(cnt); swapCount = 3'(sw);
    #1;
    isIntr = a[8:2] == 1;
    expRdy = isIntr || !mValid || rdy;
    check("R9 read", rdData, expRead(r, a, cnt, sw, mIntr));
    check("R6/R8 wrReady", {31'd0, wrReady}, {31'd0, expRdy});
    if (w && isIntr) mIntr = d & 32'h0030_003F;
    if (w && !isIntr && expRdy) begin
      mValid = 1; mAddr = a; mData = d;
    end else if (mValid && rdy) begin
      mValid = 0;
    end
    @(negedge clk);
    checkFwd("R7 forward");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] addrs [5];
    addrs[0] = 9'h000; addrs[1] = 9'h004; addrs[2] = 9'h008;
    addrs[3] = 9'h010; addrs[4] = 9'h1FC;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R5: reset state
    rdEn = 1; regAddr = 9'h004; #1;
    check("R5 intr reset", rdData, 0);
    check("R5 fwdValid reset", {31'd0, fwdValid}, 0);
    rstN = 1;
    @(negedge clk);
    // R1 R2 R3 boundaries
    cycle(1, 0, 9'h000, 0, 0, 0, 0);
    check("R1 R2 empty", expStatus(0, 0), 32'h0000_001F);
    cycle(1, 0, 9'h000, 0, 0, 1, 6);
    cycle(1, 0, 9'h000, 0, 0, 31, 3);
    cycle(1, 0, 9'h000, 0, 0, 32, 7);
    check("R1 saturated", expStatus(32, 7), 32'h0000_0020);
    cycle(1, 0, 9'h000, 0, 0, 127, 2);
    cycle(1, 0, 9'h002, 0, 0, 5, 1);
    cycle(0, 0, 9'h000, 0, 0, 5, 1);
    cycle(1, 0, 9'h0F0, 0, 0, 5, 1);
    // R4: masking
    cycle(0, 1, 9'h004, 32'hFFFF_FFFF, 0, 0, 0);
    cycle(1, 0, 9'h004, 0, 0, 0, 0);
    check("R4 mask", mIntr, 32'h0030_003F);
    // R7 R8: stall ordering
    cycle(0, 1, 9'h010, 32'hAAAA_0001, 0, 0, 0);
    cycle(0, 1, 9'h020, 32'hBBBB_0002, 0, 0, 0);
    cycle(0, 1, 9'h004, 32'h0010_0001, 0, 0, 0);
    cycle(1, 0, 9'h004, 0, 0, 0, 0);
    check("R6 no forward", {23'd0, fwdAddr}, 32'h10);
    cycle(0, 1, 9'h020, 32'hBBBB_0002, 1, 0, 0);
    cycle(0, 0, 9'h000, 0, 1, 0, 0);
    check("R8 drained", {31'd0, fwdValid}, 0);
    // random phase
    for (int i = 0; i < 400; i++) begin
      cycle(1'($urandom), 1'($urandom), addrs[$urandom % 5], $urandom,
            ($urandom % 3) != 0, int'($urandom % 40), int'($urandom % 8));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule